// File: doc/BRIEF.md
# Smart-Card Serial Transceiver

This block sends and receives byte frames on a single-wire smart-card link, with the receive and transmit halves brought out as separate pins. Every frame carries one data byte and an even parity bit, framed by a low start bit and a high stop bit. A one-cycle `bit_tick` enable paces the block. Each bit period lasts `OS` ticks, and the receiver uses those ticks as its oversampling grid. The block supports both data conventions. In the plain convention the least significant bit is sent first at true levels. In the inverted convention the most significant bit is sent first and every data level is inverted.

When error signalling is enabled, the block answers a received frame with bad parity by pulling its transmit line low for one bit period, starting at the stop bit. The transmitter helps the far end do the same: it releases the line during its own stop bit, checks the receive line for a low level there, and reports the result together with a transmit-complete pulse. That pulse comes half a bit later than it does when error signalling is off. The transmit line is a driver enable plus a data level. The pad is released (high impedance) whenever the enable is low.

Top module: `sc_uart_card`

## Requirements
- R1: A transmit frame is, in line order, one start bit (low), eight data bits, one parity bit and one stop bit (high). Each bit lasts `OS` ticks. The start bit appears on the cycle after `tx_go` is accepted.
- R2: Parity is even and is computed over the line levels. The XOR of the eight data line levels and the parity line level is 0 in both conventions.
- R3: With `inverse_en` = 0, data bit 0 is the first data bit on the line and all levels are true. A received byte is rebuilt the same way.
- R4: With `inverse_en` = 1, data bit 7 goes first and each data bit is inverted on the line. A received frame is converted back, so `rx_byte` equals the byte the far end meant to send.
- R5: The receiver samples each bit at its middle, counting ticks from the detected start bit. It pulses `rx_done` for one cycle near the middle of the stop bit and presents `rx_byte` and `rx_parity_err` at the same time.
- R6: A start low that has ended by the middle of the start bit is discarded. It produces no `rx_done`, and the next real frame is received correctly.
- R7: When `errsig_en` = 1 and parity fails, `line_oe` = 1 and `line_out` = 0 from the end of the parity bit for one bit period, and then the line is released. With a good parity, or with `errsig_en` = 0, the line is not driven.
- R8: `tx_done` is a one-cycle pulse. It comes `11*OS` ticks after acceptance when `errsig_en` = 0, and `11*OS + OS/2` ticks after acceptance when it is 1.
- R9: With `errsig_en` = 1 the stop bit is not driven (`line_oe` = 0), and `rx_line` is sampled half a bit into the stop bit. `tx_nack` pulses with `tx_done` if that sample was low and stays 0 otherwise. With `errsig_en` = 0 the stop bit is driven high.
- R10: After reset, and whenever neither half is active, `line_oe` = 0. A `tx_go` pulse during a frame is ignored and does not change the frame on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Oversample enable, `OS` per bit |
| rx_line | input | 1 | Receive line from the card |
| tx_byte | input | 8 | Byte to transmit |
| tx_go | input | 1 | Start strobe for a transmit frame |
| errsig_en | input | 1 | Enable error signalling and the delayed completion |
| inverse_en | input | 1 | 1 selects the inverted, MSB-first convention |
| line_out | output | 1 | Transmit line level when driven |
| line_oe | output | 1 | Transmit driver enable, 0 = high impedance |
| rx_byte | output | 8 | Last received byte |
| rx_done | output | 1 | One-cycle receive-complete pulse |
| rx_parity_err | output | 1 | Parity result of the last frame, valid with `rx_done` |
| tx_done | output | 1 | One-cycle transmit-complete pulse |
| tx_nack | output | 1 | Far-end error seen in the stop bit, valid with `tx_done` |

## Verification
The hardest situation to reach is a far-end low that falls exactly in the transmitter's released stop window. The receiver sees the same low as the start of a frame, so a receive can begin during a transmit. The bench pulls `rx_line` low from the ninth transmitted bit through the stop window, then releases it and lets the spurious receive end before it checks anything else. The error-signal window is checked a few ticks inside its expected edges, because start detection can land anywhere within one tick.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

  localparam int unsigned SCU_DW = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_STOP} tx_state_t;

  // Byte -> line order (index 0 leaves first), convention applied
  function automatic logic [SCU_DW-1:0] byte_to_line(input logic [SCU_DW-1:0] b,
                                                     input logic inv);
    logic [SCU_DW-1:0] r;
    for (int k = 0; k < SCU_DW; k++) begin
      r[k] = inv ? ~b[SCU_DW-1-k] : b[k];
    end
    return r;
  endfunction

  // Line order -> byte, inverse of byte_to_line
  function automatic logic [SCU_DW-1:0] line_to_byte(input logic [SCU_DW-1:0] l,
                                                     input logic inv);
    logic [SCU_DW-1:0] r;
    for (int k = 0; k < SCU_DW; k++) begin
      if (inv) r[SCU_DW-1-k] = ~l[k];
      else     r[k]          = l[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/sc_uart_rx.sv
module sc_uart_rx
  import sc_uart_pkg::*;
#(
  parameter int unsigned OS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              err_en,
  input  logic              inv,
  output logic [SCU_DW-1:0] data_o,
  output logic              valid_o,
  output logic              perr_o,
  output logic              drive_o
);

  localparam int unsigned HALF = OS / 2;
  localparam int unsigned CW   = $clog2(OS + HALF);
  localparam logic [CW-1:0] C_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] C_BIT  = CW'(OS - 1);
  localparam logic [CW-1:0] C_EXT  = CW'(OS + HALF - 1);
  localparam logic [3:0]    LAST_D = 4'(SCU_DW);

  rx_state_t         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d;
  logic [SCU_DW-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              pend_q, pend_d;
  logic              en_q, en_d;
  logic              inv_q, inv_d;
  logic              drv_q, drv_d;
  logic              val_q, val_d;
  logic              perr_q, perr_d;
  logic [SCU_DW-1:0] dat_q, dat_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    pend_d = pend_q;
    en_d   = en_q;
    inv_d  = inv_q;
    drv_d  = drv_q;
    val_d  = 1'b0;
    perr_d = perr_q;
    dat_d  = dat_q;
    unique case (st_q)
      RX_IDLE: begin
        if (tick && !rx_s) begin
          st_d  = RX_START;
          cnt_d = '0;
          en_d  = err_en;
          inv_d = inv;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == C_HALF) begin
            cnt_d = '0;
            idx_d = '0;
            par_d = 1'b0;
            st_d  = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          if (cnt_q == C_BIT) begin
            cnt_d = '0;
            if (idx_q == LAST_D) begin
              pend_d = par_q ^ rx_s;
              st_d   = RX_STOP;
            end else begin
              sh_d  = {rx_s, sh_q[SCU_DW-1:1]};
              par_d = par_q ^ rx_s;
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == C_HALF && pend_q && en_q) drv_d = 1'b1;
          if (cnt_q == C_BIT) begin
            val_d  = 1'b1;
            dat_d  = line_to_byte(sh_q, inv_q);
            perr_d = pend_q;
            if (!drv_q) st_d = RX_IDLE;
          end
          if (cnt_q == C_EXT) begin
            drv_d = 1'b0;
            st_d  = RX_IDLE;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      inv_q  <= 1'b0;
      drv_q  <= 1'b0;
      val_q  <= 1'b0;
      perr_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      pend_q <= pend_d;
      en_q   <= en_d;
      inv_q  <= inv_d;
      drv_q  <= drv_d;
      val_q  <= val_d;
      perr_q <= perr_d;
      dat_q  <= dat_d;
    end
  end

  assign data_o  = dat_q;
  assign valid_o = val_q;
  assign perr_o  = perr_q;
  assign drive_o = drv_q;

  // R7: error drive only for an enabled frame with failed parity
  assert_drive_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q |-> (en_q && pend_q && st_q == RX_STOP));
  // R5: completion is a single-cycle pulse
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);
  // R6: a frame only reaches data bits through a confirmed start
  assert_start_confirm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && st_d == RX_DATA) |-> !rx_s);

endmodule

// File: rtl/sc_uart_tx.sv
module sc_uart_tx
  import sc_uart_pkg::*;
#(
  parameter int unsigned OS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic [SCU_DW-1:0] byte_i,
  input  logic              err_en,
  input  logic              inv,
  input  logic              rx_s,
  output logic              line_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              nack_o
);

  localparam int unsigned HALF = OS / 2;
  localparam int unsigned CW   = $clog2(OS + HALF);
  localparam int unsigned FW   = SCU_DW + 2;
  localparam logic [CW-1:0] C_HALF = CW'(HALF - 1);
  localparam logic [CW-1:0] C_BIT  = CW'(OS - 1);
  localparam logic [CW-1:0] C_EXT  = CW'(OS + HALF - 1);
  localparam logic [3:0]    LAST_B = 4'(FW - 1);

  tx_state_t         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [3:0]        idx_q, idx_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic              en_q, en_d;
  logic              low_q, low_d;
  logic              done_q, done_d;
  logic              nack_q, nack_d;
  logic [SCU_DW-1:0] lb;
  logic [CW-1:0]     stop_end;

  assign lb       = byte_to_line(byte_i, inv);
  assign stop_end = en_q ? C_EXT : C_BIT;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    en_d   = en_q;
    low_d  = low_q;
    done_d = 1'b0;
    nack_d = 1'b0;
    unique case (st_q)
      TX_IDLE: begin
        if (go) begin
          sh_d  = {^lb, lb, 1'b0};
          cnt_d = '0;
          idx_d = '0;
          en_d  = err_en;
          low_d = 1'b0;
          st_d  = TX_SEND;
        end
      end
      TX_SEND: begin
        if (tick) begin
          if (cnt_q == C_BIT) begin
            cnt_d = '0;
            sh_d  = {1'b1, sh_q[FW-1:1]};
            if (idx_q == LAST_B) st_d = TX_STOP;
            else                 idx_d = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      TX_STOP: begin
        if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == C_HALF && en_q) low_d = !rx_s;
          if (cnt_q == stop_end) begin
            done_d = 1'b1;
            nack_d = en_q & low_q;
            st_d   = TX_IDLE;
          end
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '1;
      en_q   <= 1'b0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      en_q   <= en_d;
      low_q  <= low_d;
      done_q <= done_d;
      nack_q <= nack_d;
    end
  end

  assign oe_o   = (st_q == TX_SEND) | (st_q == TX_STOP && !en_q);
  assign line_o = (st_q == TX_SEND) ? sh_q[0] : 1'b1;
  assign done_o = done_q;
  assign nack_o = nack_q;

  // R8: completion is a single-cycle pulse following the stop phase
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(st_q) == TX_STOP);
  // R9: far-end error is only reported with completion
  assert_nack_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nack_q |-> done_q);
  // R10: a start strobe during a frame leaves the frame untouched
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_SEND && go && !tick) |=> $stable(sh_q));

endmodule

// File: rtl/sc_uart_line.sv
module sc_uart_line (
  input  logic rx_drive,
  input  logic tx_oe,
  input  logic tx_lvl,
  output logic pad_o,
  output logic pad_oe
);

  // Receive error signalling overrides the transmitter
  always_comb begin
    pad_oe = rx_drive | tx_oe;
    pad_o  = rx_drive ? 1'b0 : tx_lvl;
  end

endmodule

// File: rtl/sc_uart_card.sv
module sc_uart_card
  import sc_uart_pkg::*;
#(
  parameter int unsigned OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_line,
  input  logic [7:0] tx_byte,
  input  logic       tx_go,
  input  logic       errsig_en,
  input  logic       inverse_en,
  output logic       line_out,
  output logic       line_oe,
  output logic [7:0] rx_byte,
  output logic       rx_done,
  output logic       rx_parity_err,
  output logic       tx_done,
  output logic       tx_nack
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] rx_sync_q;
  logic       rx_s;
  logic       rx_drive, t_oe, t_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rx_sync_q <= 2'b11;
    else            rx_sync_q <= {rx_sync_q[0], rx_line};
  end
  assign rx_s = rx_sync_q[1];

  sc_uart_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .tick(bit_tick), .rx_s(rx_s),
    .err_en(errsig_en), .inv(inverse_en),
    .data_o(rx_byte), .valid_o(rx_done), .perr_o(rx_parity_err), .drive_o(rx_drive)
  );

  sc_uart_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .tick(bit_tick), .go(tx_go), .byte_i(tx_byte),
    .err_en(errsig_en), .inv(inverse_en), .rx_s(rx_s),
    .line_o(t_lvl), .oe_o(t_oe), .done_o(tx_done), .nack_o(tx_nack)
  );

  sc_uart_line u_line (
    .rx_drive(rx_drive), .tx_oe(t_oe), .tx_lvl(t_lvl),
    .pad_o(line_out), .pad_oe(line_oe)
  );

endmodule

// File: tb/tb_sc_uart_card.sv
module tb_sc_uart_card;

  localparam int OS = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx_line = 1'b1;
  logic tx_go = 1'b0, errsig_en = 1'b0, inverse_en = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic line_out, line_oe, rx_done, rx_parity_err, tx_done, tx_nack;
  logic [7:0] rx_byte;

  sc_uart_card #(.OS(OS)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(tick), .rx_line(rx_line), .tx_byte(tx_byte),
    .tx_go(tx_go), .errsig_en(errsig_en), .inverse_en(inverse_en),
    .line_out(line_out), .line_oe(line_oe), .rx_byte(rx_byte), .rx_done(rx_done),
    .rx_parity_err(rx_parity_err), .tx_done(tx_done), .tx_nack(tx_nack)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int tdiv = 0, ticks_seen = 0;
  int rx_total = 0, done_total = 0, mism_total = 0;
  logic [7:0] last_rx;
  logic last_perr;
  logic cmp_en = 1'b0;

  always @(negedge clk) begin
    tdiv <= tdiv + 1;
    tick <= ((tdiv % 4) == 3);
  end
  always @(posedge clk) if (tick) ticks_seen <= ticks_seen + 1;

  // Behavioural transmit model
  bit m_busy = 0, m_en = 0, m_low = 0, m_done = 0, m_err = 0;
  int m_n = 0;
  logic [9:0] m_fr;

  function automatic logic [7:0] to_line(input logic [7:0] d, input logic inv);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = inv ? ~d[7-k] : d[k];
    return r;
  endfunction

  always @(posedge clk) begin
    m_done = 0;
    m_err  = 0;
    if (!m_busy && tx_go) begin
      m_busy = 1; m_n = 0; m_en = errsig_en; m_low = 0;
      m_fr = {^to_line(tx_byte, inverse_en), to_line(tx_byte, inverse_en), 1'b0};
    end else if (m_busy && tick) begin
      m_n++;
      if (m_n == 11*OS - OS/2 && m_en) m_low = !rx_line;
      if (m_n == (m_en ? 11*OS + OS/2 : 11*OS)) begin
        m_busy = 0; m_done = 1; m_err = m_en & m_low;
      end
    end
  end

  always @(negedge clk) begin
    bit e_oe, e_o;
    e_oe = 0; e_o = 1;
    if (m_busy) begin
      if (m_n / OS < 10) begin e_oe = 1; e_o = m_fr[m_n / OS]; end
      else e_oe = !m_en;
    end
    if (cmp_en && (line_oe !== e_oe || (e_oe && line_out !== e_o) ||
                   tx_done !== m_done || tx_nack !== m_err))
      mism_total <= mism_total + 1;
    if (rx_done) begin
      rx_total <= rx_total + 1; last_rx <= rx_byte; last_perr <= rx_parity_err;
    end
    if (tx_done) done_total <= done_total + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int t;
    t = ticks_seen + n;
    while (ticks_seen < t) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] d, input bit inv, input bit en,
                         input bit far_low, input bit poke, input string req);
    int mb, db, t0, lat;
    mb = mism_total; db = done_total;
    errsig_en = en; inverse_en = inv; tx_byte = d;
    @(negedge clk); tx_go = 1; cmp_en = 1;
    @(negedge clk); tx_go = 0; t0 = ticks_seen;
    if (poke) begin
      wait_ticks(3*OS + 2);
      tx_byte = ~d; tx_go = 1; @(negedge clk); tx_go = 0; tx_byte = d;
    end
    if (far_low) begin
      while (m_n < 9*OS) @(negedge clk);
      rx_line = 0;
    end
    while (!tx_done) @(negedge clk);
    lat = ticks_seen - t0;
    @(negedge clk); @(negedge clk);
    cmp_en = 0; rx_line = 1;
    chk(mism_total == mb, req, "per-clock line mismatches", mism_total - mb, 0);
    chk(lat == (en ? 11*OS + OS/2 : 11*OS), "R8", "done latency ticks",
        lat, en ? 11*OS + OS/2 : 11*OS);
    chk(done_total - db == 1, "R8", "done pulses", done_total - db, 1);
    if (far_low) wait_ticks(14*OS);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit inv, input bit flip,
                         input bit en, input string req);
    logic [7:0] lb;
    int rb;
    bit bad;
    rb = rx_total; bad = flip;
    errsig_en = en; inverse_en = inv;
    lb = to_line(d, inv);
    rx_line = 0; wait_ticks(OS);
    for (int k = 0; k < 8; k++) begin rx_line = lb[k]; wait_ticks(OS); end
    rx_line = (^lb) ^ flip;
    wait_ticks(OS - 4);
    chk(line_oe == 0, "R7", "line before stop", line_oe, 0);
    wait_ticks(4); rx_line = 1;
    wait_ticks(OS/2);
    chk((line_oe && !line_out) == (en && bad), "R7", "error drive in window",
        line_oe && !line_out, en && bad);
    wait_ticks(OS + 4);
    chk(line_oe == 0, "R7", "released after window", line_oe, 0);
    wait_ticks(OS/2);
    chk(rx_total - rb == 1, req, "receive completions", rx_total - rb, 1);
    chk(last_rx == d, req, "received byte", last_rx, d);
    chk(last_perr == bad, "R2", "parity flag", last_perr, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_oe == 0, "R10", "oe during reset", line_oe, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(line_oe == 0 && tx_done == 0 && rx_done == 0, "R10", "idle after reset",
        {line_oe, tx_done, rx_done}, 0);

    send_tx(8'hA5, 0, 0, 0, 1, "R3");   // direct, R1 framing, R10 ignored start
    send_tx(8'h3C, 1, 0, 0, 0, "R4");   // inverse convention
    send_tx(8'h01, 0, 1, 0, 0, "R9");   // released stop, no far-end error
    send_tx(8'hF0, 1, 1, 1, 0, "R9");   // far-end error in stop window
    send_tx(8'h7E, 0, 0, 0, 0, "R1");

    send_rx(8'h5A, 0, 0, 1, "R5");      // good parity, direct
    send_rx(8'h5A, 0, 1, 1, "R7");      // bad parity, signalled
    send_rx(8'h96, 0, 1, 0, "R7");      // bad parity, signalling off
    send_rx(8'hC3, 1, 0, 1, "R4");      // inverse, good parity
    send_rx(8'h2B, 1, 1, 1, "R4");      // inverse, bad parity

    begin : glitch_R6
      int rb;
      rb = rx_total;
      rx_line = 0; wait_ticks(OS/4); rx_line = 1; wait_ticks(2*OS);
      chk(rx_total == rb, "R6", "no frame from glitch", rx_total - rb, 0);
      send_rx(8'h81, 0, 0, 1, "R6");
    end

    chk(line_oe == 0, "R10", "idle at end", line_oe, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule